// File: doc/BRIEF.md
# Real-Time Counter with Shadow Load and Snapshot Handshake

This block keeps wall-clock time as a chain of byte-wide fields: hundredths of a second, seconds, minutes, hours and a 16-bit day number. A one-cycle tick input, pulsed every 10 ms by the surrounding clocking logic, moves the chain forward. Software never writes or reads the running fields directly. It reaches them through a byte-wide register port with 7-bit addresses.

To set the clock, software fills six staging registers and then raises a load request in the control register. To read the clock, software raises a snapshot request and polls until that bit drops. It then reads a frozen, mutually consistent copy of all six fields. Both requests clear themselves a fixed number of cycles after they are raised. A bypass flag in the control register makes the visible count registers track the running fields instead of the frozen copy.

Top module: `rtc_shadow_counter`

## Requirements
- R1: After reset, every register reads 0x00: the running fields, the frozen copy, the staging registers and the control register.
- R2: The hundredths field (address 0x00) advances by one on each clock edge where `tick` is high. After 99 it returns to 0 and carries into seconds. Without a tick and without a load completing, the running fields hold their values.
- R3: Seconds (0x01) and minutes (0x02) wrap from 59 to 0, and hours (0x03) wraps from 23 to 0. Each wrap carries into the next field. The day number is day low byte (0x04) plus day high byte (0x05) shifted left by 8, and it wraps from 0xFFFF to 0x0000.
- R4: The staging registers at 0x0C..0x11 hold the same field order as 0x00..0x05 and can be written and read back. Writing them changes neither the running fields nor the frozen copy.
- R5: Writing the control register at 0x12 with bit 0 set raises the load request, and bit 0 reads 1 for LAT (default 3) clock edges. On the LAT-th edge the running fields take the staging values and bit 0 reads 0. A tick on that edge is lost.
- R6: Writing 0x12 with bit 1 set raises the snapshot request, and bit 1 reads 1 for LAT edges. On the LAT-th edge the frozen copy takes the running fields as they stood just before that edge, and bit 1 clears. At any other time the frozen copy holds its value.
- R7: Control bit 2 is the bypass flag. It is written and read back directly. While it is 1, reads of 0x00..0x05 return the running fields. While it is 0, those reads return the frozen copy.
- R8: Writing a 0 to bit 0 or bit 1 does not cancel a pending request, and writing a 1 to a request that is already pending does not restart it. Writes to 0x00..0x05 and to unmapped addresses change nothing. Unmapped addresses read 0x00, and control bits 7..3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse every 10 ms |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |

## Verification
The assertions assume that `tick` is a single-cycle pulse. They also assume that loaded values for the hundredths, seconds, minutes and hours fields stay inside their ranges, so that a wrap always comes from the limit value itself. The random stimulus draws load values only from inside those ranges, and separately draws writes aimed at read-only and unmapped addresses. Ticks are dense, which lets carries and request completions collide with ticks and with writes. A directed case loads the all-maximum time and ticks once to exercise the complete wrap.

// File: rtl/rtc_shadow_counter.sv
module rtc_shadow_counter #(
  parameter int LAT = 3,
  parameter int AW  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata
);
  localparam int NF = 6;
  localparam int CW = $clog2(LAT + 1);
  localparam logic [AW-1:0] LD_BASE = AW'(12);
  localparam logic [AW-1:0] CTL_A   = AW'(18);

  logic [7:0] live [NF];
  logic [7:0] view [NF];
  logic [7:0] stg  [NF];
  logic [7:0] inc  [NF];
  logic       ld_pend, lk_pend, byp;
  logic [CW-1:0] ld_cnt, lk_cnt;

  wire ctl_wr = bus_we && bus_addr == CTL_A;
  wire ld_now = ld_pend && ld_cnt == CW'(1);
  wire lk_now = lk_pend && lk_cnt == CW'(1);
  wire [15:0] day = {live[5], live[4]};
  wire [15:0] day_inc = day + 16'd1;

  always_comb begin
    for (int i = 0; i < NF; i++) inc[i] = live[i];
    if (live[0] >= 8'd99) begin
      inc[0] = 8'd0;
      if (live[1] >= 8'd59) begin
        inc[1] = 8'd0;
        if (live[2] >= 8'd59) begin
          inc[2] = 8'd0;
          if (live[3] >= 8'd23) begin
            inc[3] = 8'd0;
            inc[4] = day_inc[7:0];
            inc[5] = day_inc[15:8];
          end else inc[3] = live[3] + 8'd1;
        end else inc[2] = live[2] + 8'd1;
      end else inc[1] = live[1] + 8'd1;
    end else inc[0] = live[0] + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        live[i] <= '0;
        view[i] <= '0;
        stg[i]  <= '0;
      end
      ld_pend <= 1'b0;
      lk_pend <= 1'b0;
      ld_cnt  <= '0;
      lk_cnt  <= '0;
      byp     <= 1'b0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (ld_now) live[i] <= stg[i];
        else if (tick) live[i] <= inc[i];
        if (lk_now) view[i] <= live[i];
        if (bus_we && bus_addr == LD_BASE + AW'(i)) stg[i] <= bus_wdata;
      end
      if (ld_pend) begin
        if (ld_now) ld_pend <= 1'b0;
        else ld_cnt <= ld_cnt - CW'(1);
      end else if (ctl_wr && bus_wdata[0]) begin
        ld_pend <= 1'b1;
        ld_cnt  <= CW'(LAT);
      end
      if (lk_pend) begin
        if (lk_now) lk_pend <= 1'b0;
        else lk_cnt <= lk_cnt - CW'(1);
      end else if (ctl_wr && bus_wdata[1]) begin
        lk_pend <= 1'b1;
        lk_cnt  <= CW'(LAT);
      end
      if (ctl_wr) byp <= bus_wdata[2];
    end
  end

  wire [AW-1:0] ld_off = bus_addr - LD_BASE;

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr < AW'(NF))
      bus_rdata = byp ? live[bus_addr[2:0]] : view[bus_addr[2:0]];
    else if (bus_addr >= LD_BASE && bus_addr < LD_BASE + AW'(NF))
      bus_rdata = stg[ld_off[2:0]];
    else if (bus_addr == CTL_A)
      bus_rdata = {5'b0, byp, lk_pend, ld_pend};
  end

  wire [47:0] live_w = {live[5], live[4], live[3], live[2], live[1], live[0]};
  wire [47:0] view_w = {view[5], view[4], view[3], view[2], view[1], view[0]};
  wire [47:0] stg_w  = {stg[5], stg[4], stg[3], stg[2], stg[1], stg[0]};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ld_now |=> live_w == $past(live_w));
  p_cs_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_now && live[0] == 8'd99 |=> live[0] == 8'd0);
  p_day_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ld_now && live_w == 48'hFFFF_17_3B_3B_63 |=> live_w == 48'd0);
  p_load_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_pend) |-> live_w == $past(stg_w));
  p_snap_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lk_pend) |-> view_w == $past(live_w));
  p_view_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_now |=> view_w == $past(view_w));
endmodule

// File: tb/rtc_shadow_counter_test.sv
module rtc_shadow_counter_test;
  localparam int LAT = 3;
  logic clk = 0, rst_n = 0, tick = 0, bus_we = 0;
  logic [6:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  rtc_shadow_counter #(.LAT(LAT), .AW(7)) uut (.*);
  always #5 clk = ~clk;

  int m_live [6];
  int m_view [6];
  int m_stg  [6];
  int m_ldc, m_lkc;
  bit m_ldp, m_lkp, m_byp;

  function automatic void model_reset();
    for (int i = 0; i < 6; i++) begin m_live[i] = 0; m_view[i] = 0; m_stg[i] = 0; end
    m_ldp = 0; m_lkp = 0; m_byp = 0; m_ldc = 0; m_lkc = 0;
  endfunction

  function automatic void model_tick();
    int d;
    if (m_live[0] < 99) begin m_live[0]++; return; end
    m_live[0] = 0;
    if (m_live[1] < 59) begin m_live[1]++; return; end
    m_live[1] = 0;
    if (m_live[2] < 59) begin m_live[2]++; return; end
    m_live[2] = 0;
    if (m_live[3] < 23) begin m_live[3]++; return; end
    m_live[3] = 0;
    d = ((m_live[5] << 8) | m_live[4]) + 1;
    m_live[4] = d & 255; m_live[5] = (d >> 8) & 255;
  endfunction

  function automatic void model_edge(bit we, bit [6:0] a, bit [7:0] d, bit tk);
    bit ldn = m_ldp && m_ldc == 1;
    bit lkn = m_lkp && m_lkc == 1;
    bit ctl = we && a == 7'h12;
    if (lkn) for (int i = 0; i < 6; i++) m_view[i] = m_live[i];
    if (ldn) for (int i = 0; i < 6; i++) m_live[i] = m_stg[i];
    else if (tk) model_tick();
    if (m_ldp) begin if (ldn) m_ldp = 0; else m_ldc--; end
    else if (ctl && d[0]) begin m_ldp = 1; m_ldc = LAT; end
    if (m_lkp) begin if (lkn) m_lkp = 0; else m_lkc--; end
    else if (ctl && d[1]) begin m_lkp = 1; m_lkc = LAT; end
    if (ctl) m_byp = d[2];
    if (we && a >= 7'h0C && a <= 7'h11) m_stg[a - 7'h0C] = d;
  endfunction

  function automatic int exp_rd(bit [6:0] a);
    if (a < 6) return m_byp ? m_live[a] : m_view[a];
    if (a >= 7'h0C && a <= 7'h11) return m_stg[a - 7'h0C];
    if (a == 7'h12) return {m_byp, m_lkp, m_ldp};
    return 0;
  endfunction

  task automatic cyc(bit we, bit [6:0] a, bit [7:0] d, bit tk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
    @(posedge clk);
    model_edge(we, a, d, tk);
    @(negedge clk);
    bus_we = 0; tick = 0;
  endtask

  task automatic chk(bit [6:0] a, string req);
    int e;
    bus_addr = a; #1;
    e = exp_rd(a);
    n_run++;
    if (bus_rdata !== 8'(e)) begin
      n_fail++;
      $display("FAIL %s addr=%02h got=%02h exp=%02h", req, a, bus_rdata, 8'(e));
    end
  endtask

  function automatic string req_of(bit [6:0] a);
    if (a < 6) return "R2/R3/R6/R7";
    if (a >= 7'h0C && a <= 7'h11) return "R4";
    if (a == 7'h12) return "R5/R6/R7";
    return "R8";
  endfunction

  task automatic chk_all(string req);
    for (int a = 0; a < 6; a++) chk(7'(a), req);
    chk(7'h12, req);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int r, a, v;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 19; i++) chk(7'(i), "R1");
    // R2: ticks move hundredths, seen via bypass
    cyc(1, 7'h12, 8'h04, 0);
    repeat (5) cyc(0, 0, 0, 1);
    chk(7'h00, "R2");
    // R5: load request latency
    cyc(1, 7'h0C, 8'd99, 0); cyc(1, 7'h0D, 8'd59, 0); cyc(1, 7'h0E, 8'd59, 0);
    cyc(1, 7'h0F, 8'd23, 0); cyc(1, 7'h10, 8'hFF, 0); cyc(1, 7'h11, 8'hFF, 0);
    chk_all("R4");
    cyc(1, 7'h12, 8'h05, 1);
    chk(7'h12, "R5");
    cyc(1, 7'h12, 8'h04, 1);
    chk(7'h12, "R8");
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk_all("R5");
    // R3: full wrap
    cyc(0, 0, 0, 1);
    chk_all("R3");
    // R6/R7: snapshot then hold with bypass off
    repeat (7) cyc(0, 0, 0, 1);
    cyc(1, 7'h12, 8'h02, 1);
    repeat (LAT) cyc(0, 0, 0, 1);
    chk_all("R6");
    repeat (4) cyc(0, 0, 0, 1);
    chk_all("R7");
    for (int it = 0; it < 6000; it++) begin
      r = $urandom % 16;
      if (r < 2) begin
        a = $urandom % 6;
        case (a)
          0: v = ($urandom % 2) ? 95 + $urandom % 5 : $urandom % 100;
          1, 2: v = ($urandom % 2) ? 58 + $urandom % 2 : $urandom % 60;
          3: v = ($urandom % 2) ? 22 + $urandom % 2 : $urandom % 24;
          default: v = $urandom % 256;
        endcase
        cyc(1, 7'(12 + a), 8'(v), $urandom % 2);
      end else if (r < 4) begin
        cyc(1, 7'h12, 8'($urandom), $urandom % 2);
      end else if (r == 4) begin
        a = ($urandom % 2) ? $urandom % 6 : 19 + $urandom % 109;
        cyc(1, 7'(a), 8'($urandom), $urandom % 2);
        chk(7'(a), req_of(7'(a)));
      end else begin
        cyc(0, 0, 0, ($urandom % 4) != 0);
      end
      if (it % 4 == 0) begin
        a = $urandom % 20;
        chk(7'(a), req_of(7'(a)));
      end
    end
    chk(7'h55, "R8");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule